// File: doc/BRIEF.md
# Debug Communications Mailbox

This block is a two-way 32-bit mailbox between an external debugger and a processor core. The debugger places a word in the inbound slot, and the core takes it through a coprocessor-style read. The core places a word in the outbound slot, and the debugger collects it through its register port. Each slot has a full flag. Both flags are driven out as live signals and also appear in a status word that the debugger can read.

The status word also holds snapshot copies of the two flags. The snapshot is refreshed on every status read, and each status read returns the snapshot taken by the previous one. Comparing the live flags with the snapshot lets the debugger see whether either slot changed between two polls. All state is in one clock domain with a synchronous active-high reset. Both read buses are registered and keep their value until the next read on that side.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset, `rx_full` and `tx_full` are 0, and the first status read returns the all-zero word.
- R2: The status word has the live inbound flag at bit 30, the live outbound flag at bit 29, the inbound snapshot at bit 0 and the outbound snapshot at bit 1. Bit 31 and every other bit read as 0.
- R3: A debugger write (`dbg_wr_rx`) stores `dbg_wdata` in the inbound slot and sets `rx_full` after that edge. A later core read (`core_rd`) returns the stored word on `core_rdata` one cycle after the strobe.
- R4: A core read clears `rx_full` when there is no debugger write in the same cycle. A core read while the slot is empty leaves `rx_full` at 0, and the returned data is don't-care.
- R5: A core write (`core_wr`) stores `core_wdata` in the outbound slot and sets `tx_full`. A debugger read (`dbg_rd_tx`) returns the word on `dbg_rdata` one cycle later and clears `tx_full`.
- R6: A core write while `tx_full` is 1 replaces the stored outbound word, and `tx_full` stays 1.
- R7: A debugger write while `rx_full` is 1 replaces the stored inbound word, and `rx_full` stays 1.
- R8: When a slot is written and read in the same cycle, the read returns the old word, the new word is kept, and the flag ends at 1.
- R9: The snapshot bits change only on a status read (`dbg_rd_stat`). There they take the live flag values from the cycle of that read, and the returned word carries the snapshot from before the read.
- R10: `dbg_rdata` changes only after `dbg_rd_stat` or `dbg_rd_tx`, and `core_rdata` changes only after `core_rd`. Otherwise each keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_wr_rx | input | 1 | Debugger write strobe for the inbound slot |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rd_tx | input | 1 | Debugger read strobe for the outbound slot |
| dbg_rd_stat | input | 1 | Debugger read strobe for the status word |
| dbg_rdata | output | 32 | Registered debugger read data |
| core_rd | input | 1 | Core read strobe for the inbound slot |
| core_rdata | output | 32 | Registered core read data |
| core_wr | input | 1 | Core write strobe for the outbound slot |
| core_wdata | input | 32 | Core write data |
| rx_full | output | 1 | Live inbound full flag |
| tx_full | output | 1 | Live outbound full flag |

## Verification
The assertions assume that the debugger raises at most one of `dbg_rd_tx` and `dbg_rd_stat` in any cycle. When both are raised, the status word takes the read bus while the outbound flag is still cleared, and the bus checks would not describe that case. The stimulus drives each debugger read in a cycle of its own. Collision cases pair a debugger strobe only with a core strobe. All strobes last exactly one cycle and change away from the active edge.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // Status word bit positions, counted down from the MSB for the live flags
  localparam int LIVE_RX_FROM_TOP = 2;   // bit DATA_W-2
  localparam int LIVE_TX_FROM_TOP = 3;   // bit DATA_W-3
  localparam int SNAP_RX_BIT      = 0;
  localparam int SNAP_TX_BIT      = 1;

  typedef struct packed {
    logic rx;
    logic tx;
  } flag_pair_t;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] data,
  output logic         full
);
  // A write always lands; a same-cycle drain loses to the fill
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr_en)
        data <= wdata;
      if (wr_en)
        full <= 1'b1;
      else if (rd_en)
        full <= 1'b0;
    end
  end
endmodule

// File: rtl/dcc_snap.sv
module dcc_snap
  import dcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  flag_pair_t live,
  output flag_pair_t held
);
  always_ff @(posedge clk) begin
    if (rst)
      held <= '0;
    else if (capture)
      held <= live;
  end
endmodule

// File: rtl/dcc_dbg_port.sv
module dcc_dbg_port
  import dcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_stat,
  input  logic         rd_tx,
  input  logic [W-1:0] tx_data,
  input  flag_pair_t   live,
  input  flag_pair_t   held,
  output logic [W-1:0] rdata
);
  localparam int RX_POS = W - LIVE_RX_FROM_TOP;
  localparam int TX_POS = W - LIVE_TX_FROM_TOP;

  logic [W-1:0] stat_word;

  always_comb begin
    stat_word              = '0;
    stat_word[RX_POS]      = live.rx;
    stat_word[TX_POS]      = live.tx;
    stat_word[SNAP_RX_BIT] = held.rx;
    stat_word[SNAP_TX_BIT] = held.tx;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_stat)
      rdata <= stat_word;
    else if (rd_tx)
      rdata <= tx_data;
  end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_wr_rx,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_rd_tx,
  input  logic              dbg_rd_stat,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              core_rd,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              rx_full,
  output logic              tx_full
);
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] tx_data;
  flag_pair_t        live_flags;
  flag_pair_t        held_flags;

  // Inbound: debugger fills, core drains
  dcc_slot #(.W(DATA_W)) u_rx_slot (
    .clk   (clk),
    .rst   (rst),
    .wr_en (dbg_wr_rx),
    .wdata (dbg_wdata),
    .rd_en (core_rd),
    .data  (rx_data),
    .full  (rx_full)
  );

  // Outbound: core fills, debugger drains
  dcc_slot #(.W(DATA_W)) u_tx_slot (
    .clk   (clk),
    .rst   (rst),
    .wr_en (core_wr),
    .wdata (core_wdata),
    .rd_en (dbg_rd_tx),
    .data  (tx_data),
    .full  (tx_full)
  );

  assign live_flags.rx = rx_full;
  assign live_flags.tx = tx_full;

  dcc_snap u_snap (
    .clk     (clk),
    .rst     (rst),
    .capture (dbg_rd_stat),
    .live    (live_flags),
    .held    (held_flags)
  );

  dcc_dbg_port #(.W(DATA_W)) u_dbg_port (
    .clk     (clk),
    .rst     (rst),
    .rd_stat (dbg_rd_stat),
    .rd_tx   (dbg_rd_tx),
    .tx_data (tx_data),
    .live    (live_flags),
    .held    (held_flags),
    .rdata   (dbg_rdata)
  );

  // Core read bus: an empty-slot read returns the stale word
  always_ff @(posedge clk) begin
    if (rst)
      core_rdata <= '0;
    else if (core_rd)
      core_rdata <= rx_data;
  end
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dbg_wr_rx,
  input logic              dbg_rd_tx,
  input logic              dbg_rd_stat,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              core_rd,
  input logic [DATA_W-1:0] core_rdata,
  input logic              core_wr,
  input logic              rx_full,
  input logic              tx_full
);
  // R3 R7 R8
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_rx |=> rx_full);

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !dbg_wr_rx) |=> !rx_full);

  // R5 R6 R8
  tx_set_chk: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> tx_full);

  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_tx && !core_wr) |=> !tx_full);

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg_wr_rx && !core_rd) |=> $stable(rx_full));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!core_wr && !dbg_rd_tx) |=> $stable(tx_full));

  // R2
  stat_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_stat && !dbg_rd_tx) |=>
      (dbg_rdata[DATA_W-1] == 1'b0) &&
      (dbg_rdata[DATA_W-2] == $past(rx_full)) &&
      (dbg_rdata[DATA_W-3] == $past(tx_full)) &&
      (dbg_rdata[DATA_W-4:2] == '0));

  // R10
  dbg_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg_rd_stat && !dbg_rd_tx) |=> $stable(dbg_rdata));

  // R10
  core_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !core_rd |=> $stable(core_rdata));

  // R1
  always @(posedge clk) begin
    if ($past(rst) && !rst)
      reset_flags_chk: assert (!rx_full && !tx_full);
  end
endmodule

bind dcc_mailbox dcc_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dbg_wr_rx   (dbg_wr_rx),
  .dbg_rd_tx   (dbg_rd_tx),
  .dbg_rd_stat (dbg_rd_stat),
  .dbg_rdata   (dbg_rdata),
  .core_rd     (core_rd),
  .core_rdata  (core_rdata),
  .core_wr     (core_wr),
  .rx_full     (rx_full),
  .tx_full     (tx_full)
);

// File: tb/dcc_mailbox_tb.sv
module dcc_mailbox_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dbg_wr_rx = 1'b0;
  logic [W-1:0] dbg_wdata = '0;
  logic         dbg_rd_tx = 1'b0;
  logic         dbg_rd_stat = 1'b0;
  logic [W-1:0] dbg_rdata;
  logic         core_rd = 1'b0;
  logic [W-1:0] core_rdata;
  logic         core_wr = 1'b0;
  logic [W-1:0] core_wdata = '0;
  logic         rx_full;
  logic         tx_full;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // bench-side snapshot model for R9
  logic m_snap_rx = 1'b0;
  logic m_snap_tx = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dcc_mailbox #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst),
    .dbg_wr_rx(dbg_wr_rx), .dbg_wdata(dbg_wdata),
    .dbg_rd_tx(dbg_rd_tx), .dbg_rd_stat(dbg_rd_stat), .dbg_rdata(dbg_rdata),
    .core_rd(core_rd), .core_rdata(core_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata),
    .rx_full(rx_full), .tx_full(tx_full)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] stat_exp(input logic rx, input logic tx,
                                            input logic srx, input logic stx);
    logic [W-1:0] s;
    s = '0;
    s[W-2] = rx;
    s[W-3] = tx;
    s[0]   = srx;
    s[1]   = stx;
    return s;
  endfunction

  // every op: drive at a negedge, release and sample at the following negedge
  task automatic dbg_write(input logic [W-1:0] d);
    @(negedge clk); dbg_wr_rx = 1'b1; dbg_wdata = d;
    @(negedge clk); dbg_wr_rx = 1'b0;
  endtask

  task automatic core_write(input logic [W-1:0] d);
    @(negedge clk); core_wr = 1'b1; core_wdata = d;
    @(negedge clk); core_wr = 1'b0;
  endtask

  task automatic core_read(output logic [W-1:0] d);
    @(negedge clk); core_rd = 1'b1;
    @(negedge clk); core_rd = 1'b0; d = core_rdata;
  endtask

  task automatic dbg_read_tx(output logic [W-1:0] d);
    @(negedge clk); dbg_rd_tx = 1'b1;
    @(negedge clk); dbg_rd_tx = 1'b0; d = dbg_rdata;
  endtask

  // status read, checked against the live flags and the bench snapshot model
  task automatic stat_read_check(input string req);
    logic lrx, ltx;
    @(negedge clk); dbg_rd_stat = 1'b1; lrx = rx_full; ltx = tx_full;
    @(negedge clk); dbg_rd_stat = 1'b0;
    chk(req, dbg_rdata, stat_exp(lrx, ltx, m_snap_rx, m_snap_tx));
    m_snap_rx = lrx;
    m_snap_tx = ltx;
  endtask

  task automatic t_reset;
    chk("R1 rx_full", {31'b0, rx_full}, '0);
    chk("R1 tx_full", {31'b0, tx_full}, '0);
    stat_read_check("R1 status after reset");
  endtask

  task automatic t_rx_path;
    logic [W-1:0] d;
    dbg_write(32'hA5A5_0001);
    chk("R3 rx_full set", {31'b0, rx_full}, 1);
    stat_read_check("R2 status rx live");
    core_read(d);
    chk("R3 core read data", d, 32'hA5A5_0001);
    chk("R4 rx_full cleared", {31'b0, rx_full}, 0);
  endtask

  task automatic t_empty_read;
    logic [W-1:0] d;
    core_read(d);   // data don't-care
    chk("R4 empty read keeps flag 0", {31'b0, rx_full}, 0);
  endtask

  task automatic t_tx_path;
    logic [W-1:0] d;
    core_write(32'h1234_5678);
    chk("R5 tx_full set", {31'b0, tx_full}, 1);
    stat_read_check("R2 status tx live");
    dbg_read_tx(d);
    chk("R5 debugger read data", d, 32'h1234_5678);
    chk("R5 tx_full cleared", {31'b0, tx_full}, 0);
  endtask

  task automatic t_tx_overwrite;
    logic [W-1:0] d;
    core_write(32'h0000_00AA);
    core_write(32'h0000_00BB);
    chk("R6 tx_full stays", {31'b0, tx_full}, 1);
    dbg_read_tx(d);
    chk("R6 newest word", d, 32'h0000_00BB);
  endtask

  task automatic t_rx_overwrite;
    logic [W-1:0] d;
    dbg_write(32'hCAFE_0001);
    dbg_write(32'hCAFE_0002);
    chk("R7 rx_full stays", {31'b0, rx_full}, 1);
    core_read(d);
    chk("R7 newest word", d, 32'hCAFE_0002);
  endtask

  task automatic t_collide;
    logic [W-1:0] d;
    dbg_write(32'h1111_1111);
    @(negedge clk); dbg_wr_rx = 1'b1; dbg_wdata = 32'h2222_2222; core_rd = 1'b1;
    @(negedge clk); dbg_wr_rx = 1'b0; core_rd = 1'b0;
    chk("R8 rx old word returned", core_rdata, 32'h1111_1111);
    chk("R8 rx flag set wins", {31'b0, rx_full}, 1);
    core_read(d);
    chk("R8 rx new word kept", d, 32'h2222_2222);
    core_write(32'h3333_3333);
    @(negedge clk); core_wr = 1'b1; core_wdata = 32'h4444_4444; dbg_rd_tx = 1'b1;
    @(negedge clk); core_wr = 1'b0; dbg_rd_tx = 1'b0;
    chk("R8 tx old word returned", dbg_rdata, 32'h3333_3333);
    chk("R8 tx flag set wins", {31'b0, tx_full}, 1);
    dbg_read_tx(d);
    chk("R8 tx new word kept", d, 32'h4444_4444);
  endtask

  task automatic t_snapshot;
    logic [W-1:0] d;
    stat_read_check("R9 baseline");          // both empty now
    dbg_write(32'h0BAD_F00D);
    core_write(32'h0000_0042);
    stat_read_check("R9 snapshot still old");
    core_read(d);                             // changes live rx, snapshot untouched
    stat_read_check("R9 snapshot from prior read");
    stat_read_check("R9 snapshot follows");
    dbg_read_tx(d);
  endtask

  task automatic t_hold;
    logic [W-1:0] dr, cr;
    core_write(32'h5555_AAAA);
    dbg_read_tx(dr);
    dbg_write(32'h7777_0000);
    core_read(cr);
    dbg_write(32'h9999_0000);                 // no read strobe: buses hold
    core_write(32'h8888_0000);
    chk("R10 dbg_rdata held", dbg_rdata, dr);
    chk("R10 core_rdata held", core_rdata, cr);
    core_read(cr);
    dbg_read_tx(dr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_path();
    t_empty_read();
    t_tx_path();
    t_tx_overwrite();
    t_rx_overwrite();
    t_collide();
    t_snapshot();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule